// File: doc/BRIEF.md
# Parallel-Load Serializer with Shift Freeze

This block is a parallel-in, serial-out shift register. A full word is captured from a parallel bus in one clock cycle. It is then presented one bit per clock at a serial output, most significant stage first. Each shift also takes a fresh bit in at the low end from a serial input. Several instances can therefore be chained, with one instance's serial output feeding the next one's serial input.

Control uses plain level pins sampled on the rising clock edge. A synchronous reset clears the register. An active-low load strobe captures the parallel word. A freeze input stops shifting without touching the clock, so the clock keeps running while the stored word waits. The serial output is also provided in inverted form, from its own flop.

The priority order is reset, then load, then freeze, then shift. The data path is bit-serial and has no flow control: a consumer that needs to pause the stream does so with the freeze input. For that reason there is no valid/ready handshake on either side.

Top module: `par_load_shifter`

## Requirements
- R1: When `rst` is high at a rising edge, every stage is cleared. From the next cycle `ser_out` reads 0 and `ser_out_n` reads 1.
- R2: Reset takes priority over load. A parallel word presented with `load_n` low during reset is not captured.
- R3: With `load_n` low at a rising edge, all WIDTH bits of `par_in` are captured. From the next cycle `ser_out` equals `par_in[WIDTH-1]`.
- R4: Load takes priority over `freeze`. A load with `freeze` high still captures `par_in`.
- R5: With `load_n` high and `freeze` low, each rising edge moves stage i into stage i+1. After k shifts following a load, `ser_out` equals `par_in[WIDTH-1-k]`, for k from 0 to WIDTH-1.
- R6: On each shift, stage 0 takes `ser_in`. A bit entered on shift j reaches `ser_out` after shift j+WIDTH-1.
- R7: With `load_n` high and `freeze` high, the register keeps its contents. `ser_out` is unchanged, `ser_in` is ignored, and shifting resumes from the held word once `freeze` falls.
- R8: Outside reset, `ser_out_n` is always the complement of `ser_out`.
- R9: The stage count is the parameter WIDTH (default 8, minimum 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action takes effect on its rising edge |
| rst | input | 1 | Synchronous reset, active high, clears all stages |
| load_n | input | 1 | Active-low parallel load strobe |
| freeze | input | 1 | High holds the register when not loading |
| par_in | input | WIDTH | Parallel data word; bit WIDTH-1 is presented first |
| ser_in | input | 1 | Serial data entering stage 0 on each shift |
| ser_out | output | 1 | Last stage (bit WIDTH-1) |
| ser_out_n | output | 1 | Complement of the last stage, from its own flop |

## Verification
The bench targets the priority chain. A reset with `load_n` low and an all-ones word must still read 0, because a design that let load win would present 1. A load with `freeze` high must capture, because a design that let freeze win would keep the old word. During a freeze, `ser_in` is toggled and the output is watched for several cycles. After release, the next bit is checked to prove the word was kept rather than shifted; a design that still shifted would show a zero where the pattern has a one. Each table vector drains the loaded word and then the serially entered bits. This exposes a wrong shift direction, an off-by-one in where `ser_in` enters, and an inverted output that drifts from its true partner.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_SHIFT = 2'd2,
    MODE_HOLD  = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic        rst,
  input  logic        load_n,
  input  logic        freeze,
  output shift_mode_e mode
);
  // Priority: reset, then load, then freeze, then shift (R2, R4)
  always_comb begin
    if (rst)         mode = MODE_CLEAR;
    else if (!load_n) mode = MODE_LOAD;
    else if (freeze)  mode = MODE_HOLD;
    else              mode = MODE_SHIFT;
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage
  import shift_pkg::*;
#(
  parameter logic CLR_VAL = 1'b0
) (
  input  logic        clk,
  input  shift_mode_e mode,
  input  logic        par_bit,
  input  logic        prev_bit,
  output logic        q
);
  always_ff @(posedge clk) begin
    unique case (mode)
      MODE_CLEAR: q <= CLR_VAL;
      MODE_LOAD:  q <= par_bit;
      MODE_SHIFT: q <= prev_bit;
      MODE_HOLD:  q <= q;
      default:    q <= q;
    endcase
  end
endmodule

// File: rtl/par_load_shifter.sv
module par_load_shifter
  import shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_n,
  input  logic             freeze,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int MSB = WIDTH - 1;

  shift_mode_e      mode;
  logic [WIDTH-1:0] q;
  logic             q_inv;

  shift_ctrl u_ctrl (
    .rst    (rst),
    .load_n (load_n),
    .freeze (freeze),
    .mode   (mode)
  );

  // One flop per stage; stage 0 takes ser_in (R6)
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == 0) begin : g_first
      shift_stage #(.CLR_VAL(1'b0)) u_st (
        .clk      (clk),
        .mode     (mode),
        .par_bit  (par_in[i]),
        .prev_bit (ser_in),
        .q        (q[i])
      );
    end else begin : g_rest
      shift_stage #(.CLR_VAL(1'b0)) u_st (
        .clk      (clk),
        .mode     (mode),
        .par_bit  (par_in[i]),
        .prev_bit (q[i-1]),
        .q        (q[i])
      );
    end
  end

  // Separate flop for the inverted output, tracking the last stage (R8)
  shift_stage #(.CLR_VAL(1'b1)) u_inv (
    .clk      (clk),
    .mode     (mode),
    .par_bit  (~par_in[MSB]),
    .prev_bit (~q[MSB-1]),
    .q        (q_inv)
  );

  assign ser_out   = q[MSB];
  assign ser_out_n = q_inv;

  initial assert (WIDTH >= 2) else $error("WIDTH must be at least 2 (R9)");

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (ser_out == 1'b0 && ser_out_n == 1'b1));

  assert_load_capture_R3: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> ser_out == $past(par_in[MSB]));

  assert_shift_step_R5: assert property (@(posedge clk) disable iff (rst)
    (load_n && !freeze) |=> ser_out == $past(q[MSB-1]));

  assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (load_n && freeze) |=> $stable(q));

  assert_complement_R8: assert property (@(posedge clk) disable iff (rst)
    ser_out_n != ser_out);
endmodule

// File: tb/sim_par_load_shifter.sv
module sim_par_load_shifter;
  localparam int W = 8;
  localparam int NV = 5;
  // {par_in, serial fill word}
  localparam logic [15:0] VEC [NV] = '{
    16'hA5_3C, 16'h01_80, 16'hFF_00, 16'h00_FF, 16'h96_69
  };

  logic clk = 1'b0;
  logic rst, load_n, freeze, ser_in;
  logic [W-1:0] par_in;
  logic ser_out, ser_out_n;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  par_load_shifter #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .freeze(freeze),
    .par_in(par_in), .ser_in(ser_in), .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic exp);
    checks++;
    if (ser_out !== exp) begin
      fails++;
      $display("FAIL %s ser_out actual=%b expected=%b", req, ser_out, exp);
    end
    checks++;
    if (ser_out_n !== ~exp) begin
      fails++;
      $display("FAIL R8 ser_out_n actual=%b expected=%b", ser_out_n, ~exp);
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; load_n = 1'b1; freeze = 1'b0; ser_in = 1'b0; par_in = '0;
    @(negedge clk);
    tick();
    chk("R1", 1'b0);
    rst = 1'b0;
    tick();
    chk("R1", 1'b0);

    // Table walk: load, drain parallel word, then drain serial fill (R3, R5, R6)
    for (int v = 0; v < NV; v++) begin
      logic [7:0] pw = VEC[v][15:8];
      logic [7:0] fw = VEC[v][7:0];
      par_in = pw; load_n = 1'b0;
      tick();
      chk("R3", pw[7]);
      load_n = 1'b1;
      for (int k = 1; k <= 15; k++) begin
        ser_in = (k <= 8) ? fw[8-k] : 1'b0;
        tick();
        if (k < 8) chk("R5", pw[7-k]);
        else       chk("R6", fw[7-(k-8)]);
      end
    end

    // R2: reset wins over load of all ones
    par_in = 8'hFF; load_n = 1'b0; rst = 1'b1;
    tick();
    chk("R2", 1'b0);
    rst = 1'b0; load_n = 1'b1; ser_in = 1'b0;
    tick();
    chk("R2", 1'b0);

    // R4: load wins over freeze
    par_in = 8'h80; load_n = 1'b0; freeze = 1'b1;
    tick();
    chk("R4", 1'b1);

    // R7: freeze holds, ser_in ignored, resume from held word
    par_in = 8'hA5; load_n = 1'b0; freeze = 1'b0;
    tick();
    chk("R7", 1'b1);
    load_n = 1'b1; freeze = 1'b1;
    for (int k = 0; k < 4; k++) begin
      ser_in = k[0];
      tick();
      chk("R7", 1'b1);
    end
    freeze = 1'b0; ser_in = 1'b0;
    tick();
    chk("R7", 1'b0);
    tick();
    chk("R7", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule